// File: doc/BRIEF.md
# Strided Vector Address Generator

This block turns a short list of configuration commands into a stream of memory addresses for one vector instruction. It serves three streams at once: two operand streams that are read and one result stream that is written. Each stream has its own base address, stride, repeat count and an optional circular region. A stride above one gathers operands from scattered locations or leaves gaps between stored results. A repeat count above one issues every element address several times in a row. The circular region makes a section of memory behave as a ring buffer.

Commands only ever write a shadow copy of the settings, so a program rewrites just the fields that change. A start pulse copies the shadow set into the working set and begins the run. The block then issues two sequence positions per cycle for each stream until the programmed length is reached. Each element address is split into a bank, a word index inside that bank and a sub-word lane, according to the element size. The data memory is four word-interleaved banks of 4096 words of 32 bits. The output is a valid/ready stream: `out_valid` stays high for the whole run, and a position counts as consumed only on a cycle where both `out_valid` and `out_ready` are high. While `out_ready` is low, every output holds its value. `lane_valid[1]` marks whether the second lane carries a position; it is low in the last cycle of an odd-length run.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset, `busy`, `out_valid` and both bits of `lane_valid` are 0.
- R2: A command is written by setting `cfg_we` for one cycle. Stream commands use `cfg_cmd` 0 for base, 1 for stride, 2 for repeat count, 3 for wrap start and 4 for wrap length. Their value is `cfg_data[15:0]`, and they apply to the stream chosen by `cfg_sel`: 0 is operand X, 1 is operand Y, 2 is the result. Command 5 sets the shape and ignores `cfg_sel`: `cfg_data[15:0]` holds the length and `cfg_data[17:16]` the element size code (0 for 8-bit, 1 for 16-bit, 2 or 3 for 32-bit). Command codes 6 and 7, and a stream command with `cfg_sel` 3, change nothing.
- R3: Once a run starts, sequence position k of a stream carries address base + j·stride, where j is k divided by the repeat count (integer division), taken modulo 2^16. Positions k and k+1 appear together on lane 0 and lane 1, and each consumed cycle moves to k+2.
- R4: Each element address is issued repeat-count times in a row. A repeat count of 0 behaves as 1.
- R5: With a non-zero wrap length, a step that would give an address of at least wrap start plus wrap length gives that address minus the wrap length instead. A wrap length of 0 turns wrapping off.
- R6: A run issues exactly the effective length in positions. `lane_valid[1]` is 0 when only one position is left. `busy` and `out_valid` fall on the edge that consumes the last position.
- R7: The effective length is the programmed length, capped at 16384 for 8-bit elements, 8192 for 16-bit elements and 4096 for 32-bit elements.
- R8: For an element address a and size shift s (0, 1 or 2), the byte address is (a << s) mod 2^16. The bank is byte address bits [3:2], the word index is bits [15:4], and the lane is byte address bits [1:0] shifted right by s.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `lane_valid` and all address outputs keep their values, and no position is consumed.
- R10: Commands written during a run do not change the run in progress. They apply from the next accepted start pulse.
- R11: A start pulse is ignored while `busy` is 1. A start pulse is also ignored when the effective length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Command write strobe |
| cfg_cmd | input | 3 | Command code |
| cfg_sel | input | 2 | Stream selector for stream commands |
| cfg_data | input | 18 | Command value |
| start | input | 1 | Start pulse for a run |
| busy | output | 1 | A run is in progress |
| out_valid | output | 1 | Lane 0 carries a position |
| lane_valid | output | 2 | Per-lane valid flags |
| out_ready | input | 1 | Consumer accepts the current pair of positions |
| addr_bank | output | 12 | Bank select per stream and lane, 2 bits each |
| addr_word | output | 72 | Word index per stream and lane, 12 bits each |
| addr_lane | output | 12 | Sub-word lane per stream and lane, 2 bits each |

## Verification
The bench drives several kinds of run. A unit-stride run is mixed with wider strides in the same run, which shows that each stream steps on its own. Runs with each element size code, including the alias code 3, separate the bank, word and lane splits. Repeat counts of 0, 2 and 3 in one run check the repeat counter's boundary. Three wrap settings (a region entered part way, a region that starts at zero, and no region with an address that overflows) separate the wrap test from plain modulo overflow. Random back-pressure, over-length runs for every size, and command writes and start pulses during a run, together with a zero-length start, cover holding, capping and shadowing. Each of these runs is compared cycle by cycle against a queue of expected addresses.

// File: rtl/vag_pkg.sv
package vag_pkg;
  parameter int unsigned BANKS      = 4;
  parameter int unsigned BANK_WORDS = 4096;
  parameter int unsigned WORD_BYTES = 4;
  parameter int unsigned NSTREAM    = 3;
  parameter int unsigned LANES      = 2;

  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned WORD_W = $clog2(BANK_WORDS);
  localparam int unsigned BYTE_W = $clog2(WORD_BYTES);
  localparam int unsigned AW     = BANK_W + WORD_W + BYTE_W;
  localparam int unsigned LEN_W  = AW + 1;
  localparam int unsigned CFG_DW = AW + 2;
  localparam int unsigned SEL_W  = $clog2(NSTREAM);

  typedef enum logic [2:0] {
    CMD_BASE   = 3'd0,
    CMD_STRIDE = 3'd1,
    CMD_REPEAT = 3'd2,
    CMD_WSTART = 3'd3,
    CMD_WLEN   = 3'd4,
    CMD_SHAPE  = 3'd5
  } cmd_e;

  typedef struct packed {
    logic [AW-1:0] stride;
    logic [AW-1:0] rep;
    logic [AW-1:0] wstart;
    logic [AW-1:0] wlen;
  } step_cfg_t;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [AW-1:0] cnt;
  } pos_t;

  function automatic logic [1:0] size_shift(input logic [1:0] esz);
    return (esz > 2'(BYTE_W)) ? 2'(BYTE_W) : esz;
  endfunction

  function automatic logic [LEN_W-1:0] len_cap(input logic [1:0] sh);
    return LEN_W'((BANK_WORDS * WORD_BYTES) >> sh);
  endfunction

  // one sequence step: repeat the address or advance by stride with wrap
  function automatic pos_t next_pos(input pos_t p, input step_cfg_t c);
    pos_t          n;
    logic [AW:0]   sum;
    logic [AW:0]   lim;
    logic [AW-1:0] last;
    last = (c.rep == '0) ? '0 : c.rep - 1'b1;
    sum  = {1'b0, p.addr} + {1'b0, c.stride};
    lim  = {1'b0, c.wstart} + {1'b0, c.wlen};
    if ((c.wlen != '0) && (sum >= lim)) sum = sum - {1'b0, c.wlen};
    if (p.cnt >= last) begin
      n.addr = AW'(sum);
      n.cnt  = '0;
    end else begin
      n.addr = p.addr;
      n.cnt  = p.cnt + 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/vag_cfg.sv
module vag_cfg import vag_pkg::*; (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [2:0]                    cfg_cmd,
  input  logic [SEL_W-1:0]              cfg_sel,
  input  logic [CFG_DW-1:0]             cfg_data,
  input  logic                          load,
  input  logic                          busy,
  output logic [NSTREAM-1:0][AW-1:0]    sh_base,
  output step_cfg_t [NSTREAM-1:0]       act_step,
  output logic [AW-1:0]                 sh_len,
  output logic [1:0]                    sh_esz,
  output logic [1:0]                    act_esz
);
  step_cfg_t [NSTREAM-1:0] sh_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_base  <= '0;
      sh_step  <= '0;
      act_step <= '0;
      sh_len   <= '0;
      sh_esz   <= '0;
      act_esz  <= '0;
    end else begin
      for (int s = 0; s < NSTREAM; s++) begin
        if (cfg_we && (cfg_sel == SEL_W'(s))) begin
          case (cfg_cmd)
            CMD_BASE:   sh_base[s]        <= cfg_data[AW-1:0];
            CMD_STRIDE: sh_step[s].stride <= cfg_data[AW-1:0];
            CMD_REPEAT: sh_step[s].rep    <= cfg_data[AW-1:0];
            CMD_WSTART: sh_step[s].wstart <= cfg_data[AW-1:0];
            CMD_WLEN:   sh_step[s].wlen   <= cfg_data[AW-1:0];
            default: ;
          endcase
        end
        if (load) act_step[s] <= sh_step[s];
      end
      if (cfg_we && (cfg_cmd == CMD_SHAPE)) begin
        sh_len <= cfg_data[AW-1:0];
        sh_esz <= cfg_data[AW+1:AW];
      end
      if (load) act_esz <= sh_esz;
    end
  end

  // R10: working set never moves while a run continues
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(act_step) && $stable(act_esz)));
endmodule

// File: rtl/vag_stream.sv
module vag_stream import vag_pkg::*; (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        fire,
  input  logic [AW-1:0]               base,
  input  step_cfg_t                   cfg,
  output logic [LANES-1:0][AW-1:0]    lane_addr
);
  pos_t cur;
  pos_t chain [LANES+1];

  assign chain[0] = cur;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign chain[l+1]   = next_pos(chain[l], cfg);
      assign lane_addr[l] = chain[l].addr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (load) begin
      cur.addr <= base;
      cur.cnt  <= '0;
    end else if (fire) begin
      cur <= chain[LANES];
    end
  end

  // R4: repeat counter stays inside the programmed count
  p_rep_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rep == '0) ? (cur.cnt == '0) : (cur.cnt < cfg.rep));

  // R3: without repeat or wrap, a consumed cycle moves lane 0 by LANES strides
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cfg.rep <= AW'(1)) && (cfg.wlen == '0)) |=>
      (lane_addr[0] == AW'($past(lane_addr[0]) + LANES * $past(cfg.stride))));
endmodule

// File: rtl/vag_split.sv
module vag_split import vag_pkg::*; (
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        sh,
  output logic [BANK_W-1:0] bank,
  output logic [WORD_W-1:0] word,
  output logic [BYTE_W-1:0] lane
);
  logic [AW-1:0] byte_a;

  assign byte_a = addr << sh;
  assign bank   = byte_a[BYTE_W +: BANK_W];
  assign word   = byte_a[BYTE_W+BANK_W +: WORD_W];
  assign lane   = byte_a[BYTE_W-1:0] >> sh;
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen import vag_pkg::*; (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_we,
  input  logic [2:0]                               cfg_cmd,
  input  logic [SEL_W-1:0]                         cfg_sel,
  input  logic [CFG_DW-1:0]                        cfg_data,
  input  logic                                     start,
  output logic                                     busy,
  output logic                                     out_valid,
  output logic [LANES-1:0]                         lane_valid,
  input  logic                                     out_ready,
  output logic [NSTREAM-1:0][LANES-1:0][BANK_W-1:0] addr_bank,
  output logic [NSTREAM-1:0][LANES-1:0][WORD_W-1:0] addr_word,
  output logic [NSTREAM-1:0][LANES-1:0][BYTE_W-1:0] addr_lane
);
  logic [NSTREAM-1:0][AW-1:0]            sh_base;
  step_cfg_t [NSTREAM-1:0]               act_step;
  logic [AW-1:0]                         sh_len;
  logic [1:0]                            sh_esz;
  logic [1:0]                            act_esz;
  logic [1:0]                            act_sh;
  logic [LEN_W-1:0]                      cap_now;
  logic [LEN_W-1:0]                      len_eff;
  logic [LEN_W-1:0]                      remain;
  logic                                  accept;
  logic                                  fire;
  logic [NSTREAM-1:0][LANES-1:0][AW-1:0] lane_addr;

  assign cap_now   = len_cap(size_shift(sh_esz));
  assign len_eff   = ({1'b0, sh_len} > cap_now) ? cap_now : {1'b0, sh_len};
  assign accept    = start && !busy && (len_eff != '0);
  assign fire      = busy && out_ready;
  assign out_valid = busy;
  assign act_sh    = size_shift(act_esz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      remain <= len_eff;
    end else if (fire) begin
      if (remain <= LEN_W'(LANES)) begin
        busy   <= 1'b0;
        remain <= '0;
      end else begin
        remain <= remain - LEN_W'(LANES);
      end
    end
  end

  vag_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_cmd  (cfg_cmd),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .load     (accept),
    .busy     (busy),
    .sh_base  (sh_base),
    .act_step (act_step),
    .sh_len   (sh_len),
    .sh_esz   (sh_esz),
    .act_esz  (act_esz)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_valid
      assign lane_valid[l] = busy && (remain > LEN_W'(l));
    end
    for (genvar s = 0; s < NSTREAM; s++) begin : g_strm
      vag_stream u_strm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .fire      (fire),
        .base      (sh_base[s]),
        .cfg       (act_step[s]),
        .lane_addr (lane_addr[s])
      );
      for (genvar l = 0; l < LANES; l++) begin : g_split
        vag_split u_split (
          .addr (lane_addr[s][l]),
          .sh   (act_sh),
          .bank (addr_bank[s][l]),
          .word (addr_word[s][l]),
          .lane (addr_lane[s][l])
        );
      end
    end
  endgenerate

  // R9: outputs hold while the consumer stalls
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(lane_valid) &&
      $stable(addr_bank) && $stable(addr_word) && $stable(addr_lane)));

  // R6: consuming a cycle with an empty top lane ends the run
  p_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !lane_valid[LANES-1]) |=> !busy);

  // R7: remaining count never exceeds the cap for the running element size
  p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remain <= len_cap(act_sh)));

  // R11: a run only begins from a start pulse
  p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/test_vec_addr_gen.sv
module test_vec_addr_gen;
  import vag_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                                      rst_n;
  logic                                      cfg_we;
  logic [2:0]                                cfg_cmd;
  logic [SEL_W-1:0]                          cfg_sel;
  logic [CFG_DW-1:0]                         cfg_data;
  logic                                      start;
  logic                                      busy;
  logic                                      out_valid;
  logic [LANES-1:0]                          lane_valid;
  logic                                      out_ready;
  logic [NSTREAM-1:0][LANES-1:0][BANK_W-1:0] addr_bank;
  logic [NSTREAM-1:0][LANES-1:0][WORD_W-1:0] addr_word;
  logic [NSTREAM-1:0][LANES-1:0][BYTE_W-1:0] addr_lane;

  vec_addr_gen i_vec_addr_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_cmd    (cfg_cmd),
    .cfg_sel    (cfg_sel),
    .cfg_data   (cfg_data),
    .start      (start),
    .busy       (busy),
    .out_valid  (out_valid),
    .lane_valid (lane_valid),
    .out_ready  (out_ready),
    .addr_bank  (addr_bank),
    .addr_word  (addr_word),
    .addr_lane  (addr_lane)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  bit    mon_on = 0;
  bit    rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_req = "R1";

  // behavioural model state
  int q[3][$];
  int sh_base[3], sh_stride[3], sh_rep[3], sh_ws[3], sh_wl[3];
  int sh_len = 0, sh_esz = 0, m_sh = 0;
  int mn, ta, tby;
  bit mev;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  function automatic void build();
    int sh, cap, len;
    sh  = (sh_esz > 2) ? 2 : sh_esz;
    cap = 16384 >> sh;
    len = (sh_len > cap) ? cap : sh_len;
    if (len == 0) return;
    m_sh = sh;
    for (int s = 0; s < 3; s++) begin
      int a, c, r;
      a = sh_base[s];
      c = 0;
      r = (sh_rep[s] == 0) ? 1 : sh_rep[s];
      for (int k = 0; k < len; k++) begin
        q[s].push_back(a);
        c++;
        if (c >= r) begin
          c = 0;
          a = a + sh_stride[s];
          if (sh_wl[s] != 0 && a >= sh_ws[s] + sh_wl[s]) a = a - sh_wl[s];
          a = a & 65535;
        end
      end
    end
  endfunction

  function automatic void apply_cmd(int cmd, int sel, int data);
    int v;
    v = data & 65535;
    if (cmd == 5) begin
      sh_len = v;
      sh_esz = (data >> 16) & 3;
    end else if (sel < 3) begin
      case (cmd)
        0: sh_base[sel]   = v;
        1: sh_stride[sel] = v;
        2: sh_rep[sel]    = v;
        3: sh_ws[sel]     = v;
        4: sh_wl[sel]     = v;
        default: ;
      endcase
    end
  endfunction

  // compare at negedge, then advance the model for the coming edge
  always @(negedge clk) begin
    if (mon_on) begin
      mn  = q[0].size();
      mev = (mn > 0);
      chk(out_valid == mev, (mev ? "R6" : cur_req), "out_valid", out_valid, mev);
      chk(busy == mev, "R6", "busy", busy, mev);
      if (mev) begin
        chk(lane_valid[1] == (mn >= 2), "R6", "lane_valid[1]", lane_valid[1], (mn >= 2));
        for (int s = 0; s < 3; s++) begin
          for (int l = 0; l < 2; l++) begin
            if (l < mn) begin
              ta  = q[s][l];
              tby = (ta << m_sh) & 65535;
              chk(int'(addr_bank[s][l]) == ((tby >> 2) & 3), cur_req, "bank",
                  int'(addr_bank[s][l]), (tby >> 2) & 3);
              chk(int'(addr_word[s][l]) == (tby >> 4), cur_req, "word",
                  int'(addr_word[s][l]), tby >> 4);
              chk(int'(addr_lane[s][l]) == ((tby & 3) >> m_sh), cur_req, "lane",
                  int'(addr_lane[s][l]), (tby & 3) >> m_sh);
            end
          end
        end
        if (out_ready) begin
          for (int s = 0; s < 3; s++) begin
            void'(q[s].pop_front());
            if (mn >= 2) void'(q[s].pop_front());
          end
        end
      end
      if (start && !mev) build();
      if (cfg_we) apply_cmd(int'(cfg_cmd), int'(cfg_sel), int'(cfg_data));
    end
  end

  // consumer readiness
  always @(posedge clk) begin
    #2;
    if (rdy_mode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[5];
    end else begin
      out_ready = 1'b1;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog actual=running expected=idle");
    summary();
  end

  task automatic wr(input int cmd, input int sel, input int data);
    cfg_we   = 1'b1;
    cfg_cmd  = 3'(cmd);
    cfg_sel  = SEL_W'(sel);
    cfg_data = CFG_DW'(data);
    @(posedge clk); #2;
    cfg_we   = 1'b0;
  endtask

  task automatic strm(input int s, input int base, input int stride, input int rep,
                      input int ws, input int wl);
    wr(0, s, base);
    wr(1, s, stride);
    wr(2, s, rep);
    wr(3, s, ws);
    wr(4, s, wl);
  endtask

  task automatic shape(input int len, input int esz);
    wr(5, 0, (esz << 16) | len);
  endtask

  task automatic go();
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (q[0].size() != 0) begin
      @(posedge clk); #2;
    end
    @(posedge clk); #2;
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_cmd = '0; cfg_sel = '0; cfg_data = '0;
    start = 1'b0; out_ready = 1'b1;
    for (int s = 0; s < 3; s++) begin
      sh_base[s] = 0; sh_stride[s] = 0; sh_rep[s] = 0; sh_ws[s] = 0; sh_wl[s] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(lane_valid == '0, "R1", "lane_valid", int'(lane_valid), 0);
    mon_on = 1;

    // R3: unit stride next to gather and skip strides
    cur_req = "R3";
    strm(0, 100, 1, 1, 0, 0);
    strm(1, 140, 2, 1, 0, 0);
    strm(2, 180, 5, 1, 0, 0);
    shape(10, 2);
    go(); wait_idle();

    // R8: address split for every element size code, odd lengths
    cur_req = "R8";
    strm(0, 1, 3, 1, 0, 0);
    strm(1, 4093, 7, 1, 0, 0);
    strm(2, 50, 1, 1, 0, 0);
    shape(7, 0);  go(); wait_idle();
    shape(9, 1);  go(); wait_idle();
    shape(5, 3);  go(); wait_idle();

    // R9: random back-pressure
    cur_req = "R9";
    rdy_mode = 1;
    shape(25, 1); go(); wait_idle();
    rdy_mode = 0;

    // R4: repeat counts 3, 0 and 2
    cur_req = "R4";
    strm(0, 10, 4, 3, 0, 0);
    strm(1, 20, 4, 0, 0, 0);
    strm(2, 30, 4, 2, 0, 0);
    shape(17, 2); go(); wait_idle();

    // R5: wrap entered mid-region, region from zero, plain overflow
    cur_req = "R5";
    strm(0, 205, 3, 1, 200, 10);
    strm(1, 0, 7, 1, 0, 16);
    strm(2, 65000, 1000, 1, 0, 0);
    shape(30, 0); go(); wait_idle();

    // R2: ignored command code and selector leave the run unchanged
    cur_req = "R2";
    wr(6, 0, 999);
    wr(0, 3, 999);
    go(); wait_idle();

    // R7: over-length runs capped for each size
    cur_req = "R7";
    strm(0, 0, 1, 1, 0, 0);
    strm(1, 8, 2, 1, 0, 0);
    strm(2, 16, 1, 1, 0, 0);
    shape(65535, 2); go(); wait_idle();
    shape(9000, 1);  go(); wait_idle();
    shape(16385, 0); go(); wait_idle();

    // R10: writes during a run are shadowed; R11: start while busy ignored
    cur_req = "R10";
    strm(0, 300, 1, 1, 0, 0);
    shape(20, 2);
    go();
    @(posedge clk); #2;
    wr(0, 0, 3000);
    wr(1, 1, 9);
    wr(2, 2, 2);
    shape(8, 0);
    cur_req = "R11";
    go();
    wait_idle();
    cur_req = "R10";
    go(); wait_idle();

    // R11: zero effective length
    cur_req = "R11";
    shape(0, 2);
    go();
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R11", "out_valid after empty start", out_valid, 0);
    end
    @(posedge clk); #2;

    summary();
  end
endmodule